// File: doc/BRIEF.md
# Condition-Masked Vector Register Writeback

This unit sits at the end of a four-lane floating-point datapath and decides which lanes of a freshly computed result vector land in the destination register. Each lane passes through an optional clamp to [0,1] and is then merged into the old destination value. A lane is merged only when its static write-mask bit is set and a run-time condition test passes. The test is a rule applied to a code taken from one of two condition registers, after a lane swizzle.

The unit owns both condition registers. Each holds one two-bit code per lane: equal, less, greater or unordered. When updating is requested, a write strobe commits fresh codes for the lanes that were actually written. Each fresh code is derived from the sign, zero and NaN state of the written value, with no floating-point arithmetic. A program-start pulse sets both registers back to all-equal. The merged vector is combinational, so it can feed the register file in the same cycle as the result. Code updates take effect on the next clock edge.

Top module: `cond_vec_writeback`

## Requirements
- R1: After reset, and one cycle after `prog_start` is high at a clock edge, both condition registers hold EQ in every lane. `prog_start` takes priority over a simultaneous write strobe.
- R2: Lane i of any vector port is bits [32i+31:32i], with lane 0 being x. Lane i of `merged_vec` equals the (possibly saturated) result lane when `wmask[i]` is set and that lane's condition test passes; otherwise it equals lane i of `old_vec`. `comp_wen[i]` is high exactly for the lanes that are merged from the result.
- R3: Condition codes are encoded EQ=0, LT=1, GT=2, UN=3, and lane i of a register is bits [2i+1:2i] of `cc0_q` / `cc1_q`. The test for lane i uses the code in lane `cc_swz[2i+1:2i]` of the register selected by `cc_sel` (0 selects `cc0_q`, 1 selects `cc1_q`).
- R4: `cc_rule` is encoded TR=0, FL=1, EQ=2, NE=3, LT=4, GE=5, LE=6, GT=7. TR always passes and FL never passes. GE passes on GT or EQ, and LE passes on LT or EQ. An unordered code passes only under NE.
- R5: With `sat_en` high, a result lane that is negative and nonzero becomes +0.0, and a lane above 1.0 (including +infinity) becomes 1.0. NaN lanes and all other values, including both zeros, pass unchanged. With `sat_en` low, no lane is altered.
- R6: On a clock edge with `wr_stb` and `cc_upd` high and `prog_start` low, each written lane of the register selected by `cc_sel` takes the code of its written value. Unwritten lanes keep their code, and the other register is unchanged.
- R7: A value's code is UN for a NaN, EQ for +0.0 and -0.0, LT for any other value with the sign set, and GT otherwise.
- R8: Without `wr_stb`, or with `cc_upd` low, a clock edge leaves both condition registers unchanged (apart from `prog_start`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | Sets both condition registers to all-EQ |
| wr_stb | input | 1 | Commit strobe for condition updates |
| res_vec | input | 128 | Result vector, four single-precision lanes |
| old_vec | input | 128 | Current destination value |
| wmask | input | 4 | Static per-lane write mask |
| sat_en | input | 1 | Clamp result lanes to [0,1] |
| cc_sel | input | 1 | Condition register used for test and update |
| cc_swz | input | 8 | Four 2-bit lane indices for the code swizzle |
| cc_rule | input | 3 | Condition test rule |
| cc_upd | input | 1 | Enable condition code regeneration |
| merged_vec | output | 128 | Merged destination value |
| comp_wen | output | 4 | Lanes merged from the result |
| cc0_q | output | 8 | Condition register 0 |
| cc1_q | output | 8 | Condition register 1 |

## Verification
The hardest situation to reach is a swizzled test that reads an unordered or less-than code from a lane other than its own, in a register that is not the last one written. Codes can only be planted by writing NaN or signed values with updates enabled. The sweep therefore cycles a pool of special values through every lane while alternating the register select, the swizzle and the update enable. Both registers thus carry mixed, changing code patterns before each test rule reads them. Directed sequences then rebuild the worked examples of lane-limited updates and a reversed swizzle with NE.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int FW = 32;
  localparam logic [FW-2:0] ONE_MAG = 31'h3F80_0000;

  typedef enum logic [1:0] {CC_EQ = 2'd0, CC_LT = 2'd1, CC_GT = 2'd2, CC_UN = 2'd3} cc_t;
  typedef enum logic [2:0] {
    RL_TR = 3'd0, RL_FL = 3'd1, RL_EQ = 3'd2, RL_NE = 3'd3,
    RL_LT = 3'd4, RL_GE = 3'd5, RL_LE = 3'd6, RL_GT = 3'd7
  } rule_t;

  function automatic logic f32_nan(input logic [FW-1:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction

  function automatic logic f32_zero(input logic [FW-1:0] v);
    return v[30:0] == 31'd0;
  endfunction

  // Clamp to [0,1]; NaN passes through, signed zero is left alone.
  function automatic logic [FW-1:0] f32_clamp(input logic [FW-1:0] v);
    logic [FW-1:0] o;
    o = v;
    if (!f32_nan(v)) begin
      if (v[31] && !f32_zero(v)) o = '0;
      else if (!v[31] && (v[30:0] > ONE_MAG)) o = {1'b0, ONE_MAG};
    end
    return o;
  endfunction

  function automatic cc_t f32_code(input logic [FW-1:0] v);
    cc_t c;
    if (f32_nan(v)) c = CC_UN;
    else if (f32_zero(v)) c = CC_EQ;
    else if (v[31]) c = CC_LT;
    else c = CC_GT;
    return c;
  endfunction

  function automatic logic rule_ok(input rule_t r, input cc_t c);
    logic ok;
    case (r)
      RL_TR: ok = 1'b1;
      RL_FL: ok = 1'b0;
      RL_EQ: ok = (c == CC_EQ);
      RL_NE: ok = (c != CC_EQ);
      RL_LT: ok = (c == CC_LT);
      RL_GE: ok = (c == CC_GT) || (c == CC_EQ);
      RL_LE: ok = (c == CC_LT) || (c == CC_EQ);
      RL_GT: ok = (c == CC_GT);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/cwb_lane_sat.sv
module cwb_lane_sat
  import cwb_pkg::*;
(
  input  logic          sat_en,
  input  logic [FW-1:0] din,
  output logic [FW-1:0] dout,
  output logic [1:0]    code
);
  always_comb begin
    dout = sat_en ? f32_clamp(din) : din;
    code = f32_code(dout);
  end
endmodule

// File: rtl/cwb_cc_test.sv
module cwb_cc_test
  import cwb_pkg::*;
#(
  parameter int NLANE = 4,
  localparam int SW   = $clog2(NLANE),
  localparam int CW   = 2 * NLANE
) (
  input  logic [CW-1:0]       codes,
  input  logic [NLANE*SW-1:0] swz,
  input  logic [2:0]          rule,
  output logic [NLANE-1:0]    pass
);
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [SW-1:0] src_idx;
    logic [1:0]    picked;
    assign src_idx = swz[i*SW +: SW];
    assign picked  = codes[src_idx*2 +: 2];
    assign pass[i] = rule_ok(rule_t'(rule), cc_t'(picked));
  end
endmodule

// File: rtl/cwb_cc_bank.sv
module cwb_cc_bank #(
  parameter int NLANE = 4,
  parameter int NREG  = 2,
  localparam int CW   = 2 * NLANE,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             commit,
  input  logic [SELW-1:0]  sel,
  input  logic [NLANE-1:0] lane_wen,
  input  logic [CW-1:0]    new_codes,
  output logic [NREG*CW-1:0] bank_flat
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CW-1:0] q;
    logic          hit;
    assign hit = commit && (sel == SELW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (start) begin
        q <= '0;
      end else if (hit) begin
        for (int i = 0; i < NLANE; i++)
          if (lane_wen[i]) q[i*2 +: 2] <= new_codes[i*2 +: 2];
      end
    end
    assign bank_flat[r*CW +: CW] = q;
  end
endmodule

// File: rtl/cond_vec_writeback.sv
module cond_vec_writeback
  import cwb_pkg::*;
#(
  parameter int NLANE = 4,
  localparam int SW   = $clog2(NLANE),
  localparam int CW   = 2 * NLANE,
  localparam int VW   = FW * NLANE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              wr_stb,
  input  logic [VW-1:0]     res_vec,
  input  logic [VW-1:0]     old_vec,
  input  logic [NLANE-1:0]  wmask,
  input  logic              sat_en,
  input  logic              cc_sel,
  input  logic [NLANE*SW-1:0] cc_swz,
  input  logic [2:0]        cc_rule,
  input  logic              cc_upd,
  output logic [VW-1:0]     merged_vec,
  output logic [NLANE-1:0]  comp_wen,
  output logic [CW-1:0]     cc0_q,
  output logic [CW-1:0]     cc1_q
);
  localparam int NREG = 2;

  logic [VW-1:0]     sat_vec;
  logic [CW-1:0]     fresh_codes;
  logic [CW-1:0]     sel_codes;
  logic [NLANE-1:0]  test_pass;
  logic [NREG*CW-1:0] bank_flat;
  logic              commit_cc;

  for (genvar i = 0; i < NLANE; i++) begin : g_sat
    cwb_lane_sat u_sat (
      .sat_en (sat_en),
      .din    (res_vec[i*FW +: FW]),
      .dout   (sat_vec[i*FW +: FW]),
      .code   (fresh_codes[i*2 +: 2])
    );
  end

  assign sel_codes = cc_sel ? bank_flat[CW +: CW] : bank_flat[0 +: CW];

  cwb_cc_test #(.NLANE(NLANE)) u_test (
    .codes (sel_codes),
    .swz   (cc_swz),
    .rule  (cc_rule),
    .pass  (test_pass)
  );

  assign comp_wen = wmask & test_pass;

  for (genvar i = 0; i < NLANE; i++) begin : g_merge
    assign merged_vec[i*FW +: FW] = comp_wen[i] ? sat_vec[i*FW +: FW]
                                                : old_vec[i*FW +: FW];
  end

  assign commit_cc = wr_stb && cc_upd;

  cwb_cc_bank #(.NLANE(NLANE), .NREG(NREG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (prog_start),
    .commit    (commit_cc),
    .sel       (cc_sel),
    .lane_wen  (comp_wen),
    .new_codes (fresh_codes),
    .bank_flat (bank_flat)
  );

  assign cc0_q = bank_flat[0 +: CW];
  assign cc1_q = bank_flat[CW +: CW];
endmodule

// File: rtl/cond_vec_writeback_chk.sv
module cond_vec_writeback_chk #(
  parameter int NLANE = 4,
  localparam int SW   = $clog2(NLANE),
  localparam int CW   = 2 * NLANE,
  localparam int VW   = 32 * NLANE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_start,
  input logic              wr_stb,
  input logic [VW-1:0]     old_vec,
  input logic [NLANE-1:0]  wmask,
  input logic              sat_en,
  input logic              cc_sel,
  input logic [2:0]        cc_rule,
  input logic              cc_upd,
  input logic [VW-1:0]     merged_vec,
  input logic [NLANE-1:0]  comp_wen,
  input logic [CW-1:0]     cc0_q,
  input logic [CW-1:0]     cc1_q
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> (cc0_q == '0) && (cc1_q == '0)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_start && !(wr_stb && cc_upd)) |=> $stable(cc0_q) && $stable(cc1_q)); // R8

  AST_CC1_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_start && !cc_sel) |=> $stable(cc1_q)); // R6

  AST_CC0_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_start && cc_sel) |=> $stable(cc0_q)); // R6

  AST_WEN_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_wen & ~wmask) == '0); // R2

  AST_FL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_rule == 3'd1) |-> (comp_wen == '0)); // R4

  AST_TR_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_rule == 3'd0) |-> (comp_wen == wmask)); // R4

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [31:0] m;
    logic        m_nan;
    assign m     = merged_vec[i*32 +: 32];
    assign m_nan = (m[30:23] == 8'hFF) && (m[22:0] != 0);

    AST_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      !comp_wen[i] |-> (m == old_vec[i*32 +: 32])); // R2

    AST_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_en && comp_wen[i] && !m_nan) |->
        (m[30:0] <= 31'h3F80_0000) && !(m[31] && m[30:0] != 0)); // R5
  end
endmodule

bind cond_vec_writeback cond_vec_writeback_chk #(.NLANE(NLANE)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .wr_stb(wr_stb),
  .old_vec(old_vec), .wmask(wmask), .sat_en(sat_en), .cc_sel(cc_sel),
  .cc_rule(cc_rule), .cc_upd(cc_upd), .merged_vec(merged_vec),
  .comp_wen(comp_wen), .cc0_q(cc0_q), .cc1_q(cc1_q)
);

// File: tb/sim_cond_vec_writeback.sv
module sim_cond_vec_writeback;
  localparam int CLK_P = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         prog_start = 0, wr_stb = 0, sat_en = 0, cc_sel = 0, cc_upd = 0;
  logic [127:0] res_vec = '0, old_vec = '0;
  logic [3:0]   wmask = '0;
  logic [7:0]   cc_swz = 8'hE4;
  logic [2:0]   cc_rule = '0;
  logic [127:0] merged_vec;
  logic [3:0]   comp_wen;
  logic [7:0]   cc0_q, cc1_q;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mcc [2];

  always #(CLK_P/2) clk = ~clk;

  cond_vec_writeback u0 (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .wr_stb(wr_stb),
    .res_vec(res_vec), .old_vec(old_vec), .wmask(wmask), .sat_en(sat_en),
    .cc_sel(cc_sel), .cc_swz(cc_swz), .cc_rule(cc_rule), .cc_upd(cc_upd),
    .merged_vec(merged_vec), .comp_wen(comp_wen), .cc0_q(cc0_q), .cc1_q(cc1_q)
  );

  // pass table: nibble per rule, bit per code (EQ,LT,GT,UN)
  localparam logic [31:0] PASS_TBL = 32'h4352_E10F;

  function automatic logic [31:0] pool(input int k);
    case (k % 13)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3F80_0000;  3: return 32'h3F00_0000;
      4: return 32'h4000_0000;  5: return 32'hC000_0000;
      6: return 32'h7F80_0000;  7: return 32'hFF80_0000;
      8: return 32'h7FC0_0000;  9: return 32'hFFC0_0001;
      10: return 32'h3F80_0001; 11: return 32'h0000_0001;
      default: return 32'h8000_0001;
    endcase
  endfunction

  function automatic logic is_nan_b(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic logic [31:0] clamp_b(input logic [31:0] v);
    if (is_nan_b(v)) return v;
    if (v[31]) return (v[30:0] == 0) ? v : 32'h0;
    if (v[30:0] > 31'h3F80_0000) return 32'h3F80_0000;
    return v;
  endfunction

  function automatic logic [1:0] code_b(input logic [31:0] v);
    if (is_nan_b(v)) return 2'd3;
    if (v[30:0] == 0) return 2'd0;
    return v[31] ? 2'd1 : 2'd2;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Checks comb outputs against the model and advances the model by one edge.
  task automatic apply_and_check(input string tag);
    logic [3:0]   ew;
    logic [127:0] em;
    logic [7:0]   src;
    src = mcc[cc_sel];
    #1;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] c;
      logic [31:0] r;
      c = src[cc_swz[2*i +: 2]*2 +: 2];
      ew[i] = wmask[i] & PASS_TBL[cc_rule*4 + c];
      r = sat_en ? clamp_b(res_vec[32*i +: 32]) : res_vec[32*i +: 32];
      em[32*i +: 32] = ew[i] ? r : old_vec[32*i +: 32];
      if (prog_start == 0 && wr_stb && cc_upd && ew[i]) mcc[cc_sel][2*i +: 2] = code_b(r);
    end
    if (prog_start) begin mcc[0] = '0; mcc[1] = '0; end
    chk(comp_wen == ew, {tag, " R4 comp_wen"}, {124'd0, comp_wen}, {124'd0, ew});
    chk(merged_vec == em, {tag, " R2 merged"}, merged_vec, em);
  endtask

  task automatic check_cc(input string tag);
    chk(cc0_q == mcc[0] && cc1_q == mcc[1], tag, {112'd0, cc1_q, cc0_q}, {112'd0, mcc[1], mcc[0]});
  endtask

  task automatic step(input string tag);
    apply_and_check(tag);
    @(negedge clk);
    check_cc({tag, " R6 cc"});
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] swz_set [4];
    swz_set[0] = 8'hE4; swz_set[1] = 8'h1B; swz_set[2] = 8'h00; swz_set[3] = 8'hC6;
    mcc[0] = '0; mcc[1] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_cc("R1 reset state");

    // Worked example: full write then xyz write, updating CC0 (R7, R6)
    wr_stb = 1; cc_upd = 1; wmask = 4'hF; cc_rule = 3'd0; cc_sel = 0;
    res_vec = {32'h7FC0_0000, 32'h4000_0000, 32'h0000_0000, 32'hC000_0000};
    step("R7 example1");
    chk(cc0_q == 8'b11_10_00_01, "R7 codes LT,EQ,GT,UN", {120'd0, cc0_q}, {120'd0, 8'b11_10_00_01});
    wmask = 4'h7;
    res_vec = {32'h1234_5678, 32'h7FC0_0000, 32'h4000_0000, 32'h0000_0000};
    step("R6 example2");
    chk(cc0_q == 8'b11_11_10_00, "R6 codes EQ,GT,UN,UN", {120'd0, cc0_q}, {120'd0, 8'b11_11_10_00});

    // Swizzle example on CC1: plant (GT,LT,EQ,GT), then NE with zyxw
    cc_sel = 1; wmask = 4'hF;
    res_vec = {32'h3F80_0000, 32'h0000_0000, 32'hBF80_0000, 32'h3F80_0000};
    step("R3 plant");
    cc_upd = 0; cc_rule = 3'd3; cc_swz = 8'hC6;
    step("R3 swizzle NE");
    chk(comp_wen == 4'b1110, "R3 lanes y,z,w", {124'd0, comp_wen}, {124'd0, 4'b1110});

    // Saturation corner values (R5)
    cc_rule = 3'd0; sat_en = 1; wr_stb = 0;
    res_vec = {32'h8000_0000, 32'h7FC0_0000, 32'h7F80_0000, 32'hC000_0000};
    step("R5 sat");
    chk(merged_vec == {32'h8000_0000, 32'h7FC0_0000, 32'h3F80_0000, 32'h0000_0000},
        "R5 clamp values", merged_vec, {32'h8000_0000, 32'h7FC0_0000, 32'h3F80_0000, 32'h0000_0000});

    // Start priority over a strobe with update (R1)
    prog_start = 1; wr_stb = 1; cc_upd = 1; sat_en = 0;
    res_vec = {4{32'hC000_0000}};
    step("R1 start priority");
    prog_start = 0;

    // Sweep: every mask, rule, select, swizzle, sat and update combination
    for (int it = 0; it < 4096; it++) begin
      wmask   = it[3:0];
      cc_rule = it[6:4];
      cc_sel  = it[7];
      cc_swz  = swz_set[it[9:8]];
      sat_en  = it[10];
      cc_upd  = it[11] | it[0];
      wr_stb  = (it % 5) != 0;   // strobe gaps exercise R8
      for (int i = 0; i < 4; i++) begin
        res_vec[32*i +: 32] = pool(it * 3 + i * 5);
        old_vec[32*i +: 32] = pool(it * 7 + i + 1) ^ 32'h0000_0F00;
      end
      step("sweep R8");
    end
    finish_run();
  end
endmodule